// File: doc/BRIEF.md
# Overridable Eight-Pin GPIO Port

This block controls a small bank of general-purpose pins through a simple register bus. Software sets each pin's direction in a direction register and reads pin levels from a status register. Two peripherals can take a pin away from software control. A display segment driver takes a pin when both its per-pin enable and the display-module enable are set. A timer output-compare channel forces a pin to output when the timer is enabled and that pin is selected for compare. Display ownership wins over timer ownership. When neither owns the pin, the direction register controls it. A pin that the timer uses for input capture is not selected for compare, so the direction register still controls it.

The pad side has a registered output enable and a registered output data bit for each pin. Pad levels pass through a two-flop synchronizer before they reach the status register. A pin owned by the display reads back as 1 and drives no digital output.

Top module: `gpio_ovr_port`

## Requirements
- R1: The direction register is at address 0 and resets to all zeros. A write there stores `reg_wdata`, and the new value reads back at address 0. Bit value 1 means output and 0 means input.
- R2: The status register is at address 1 and is read-only. A write to address 1 leaves the direction register and the status readback unchanged.
- R3: When `seg_mod_en` is 1 and `seg_pin_en[i]` is 1, status bit i reads as 1 whatever the pad level.
- R4: When pin i is not display-owned, status bit i reads the pad level after a two-flop synchronizer. Take a pad change made before clock edge k. A read strobe sampled at edge k+1 returns the old level. A read strobe sampled at edge k+2 returns the new level.
- R5: For a display-owned pin, `pad_oe[i]` is 0 and `pad_out[i]` is 0. This holds regardless of the direction bit and the timer inputs.
- R6: Pin i is in compare mode when it is not display-owned, `tmr_mod_en` is 1 and `tmr_oc_sel[i]` is 1. In compare mode, `pad_oe[i]` is 1 and `pad_out[i]` equals `tmr_oc_val[i]`, regardless of the direction bit.
- R7: When pin i is neither display-owned nor in compare mode, `pad_oe[i]` equals direction bit i and `pad_out[i]` equals `port_dout[i]`. This covers a disabled timer and pins left to input capture.
- R8: `pad_oe` and `pad_out` are registered. An input change made before a clock edge appears just after that edge and not before it.
- R9: Read data appears on `reg_rdata` one cycle after the read strobe. `reg_rdata` is zero in any cycle that follows no read strobe.
- R10: Addresses 2 and 3 are unmapped. They read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | PINS | Write data |
| reg_rdata | output | PINS | Read data, one cycle after strobe |
| seg_mod_en | input | 1 | Display module enable |
| seg_pin_en | input | PINS | Per-pin display driver enable |
| tmr_mod_en | input | 1 | Timer module enable |
| tmr_oc_sel | input | PINS | Per-pin output-compare selection |
| tmr_oc_val | input | PINS | Per-pin compare output level |
| port_dout | input | PINS | Port data value for software-owned pins |
| pad_in | input | PINS | Asynchronous pad levels |
| pad_oe | output | PINS | Registered digital output enable |
| pad_out | output | PINS | Registered digital output data |

## Verification
The hardest situation to reach is one where every pin is in a different ownership state at the same moment. In that case, display, compare and direction control are all active across the bank, and each global enable changes which pins each source claims. The bench walks all four settings of the two global enables. Within each setting, it rotates a 5-bit per-pin pattern covering display enable, compare selection, compare value, direction bit and port data, offset by pin index, so every local combination lands on every pin. After each step it checks both pad outputs and a status read taken against a changing pad pattern. The synchronizer latency is pinned down separately by issuing reads exactly one and two edges after a pad change.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned ADDR_DIR  = 0;
  localparam int unsigned ADDR_STAT = 1;

  typedef enum logic [1:0] {
    PM_SOFT = 2'd0,
    PM_OC   = 2'd1,
    PM_DISP = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int PINS   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] async_in,
  output logic [PINS-1:0] sync_out
);
  logic [PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            seg_mod_en,
  input  logic [PINS-1:0] seg_pin_en,
  input  logic            tmr_mod_en,
  input  logic [PINS-1:0] tmr_oc_sel,
  input  logic [PINS-1:0] tmr_oc_val,
  input  logic [PINS-1:0] port_dout,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] pad_sync,
  output logic [PINS-1:0] stat_bits,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    pin_mode_e mode;
    logic      oe_d;
    logic      out_d;

    always_comb begin
      if (seg_mod_en && seg_pin_en[i])      mode = PM_DISP;
      else if (tmr_mod_en && tmr_oc_sel[i]) mode = PM_OC;
      else                                  mode = PM_SOFT;
    end

    always_comb begin
      unique case (mode)
        PM_DISP: begin oe_d = 1'b0; out_d = 1'b0; end
        PM_OC:   begin oe_d = 1'b1; out_d = tmr_oc_val[i]; end
        default: begin oe_d = dir_q[i]; out_d = port_dout[i]; end
      endcase
    end

    assign stat_bits[i] = (mode == PM_DISP) ? 1'b1 : pad_sync[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pad_oe[i]  <= 1'b0;
        pad_out[i] <= 1'b0;
      end else begin
        pad_oe[i]  <= oe_d;
        pad_out[i] <= out_d;
      end
    end

    AST_DISP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      (seg_mod_en && seg_pin_en[i]) |=> (!pad_oe[i] && !pad_out[i])); // R5
    AST_OC_FORCED: assert property (@(posedge clk) disable iff (rst)
      (!(seg_mod_en && seg_pin_en[i]) && tmr_mod_en && tmr_oc_sel[i])
      |=> (pad_oe[i] && pad_out[i] == $past(tmr_oc_val[i]))); // R6
    AST_SOFT_DIR: assert property (@(posedge clk) disable iff (rst)
      (!(seg_mod_en && seg_pin_en[i]) && !(tmr_mod_en && tmr_oc_sel[i]))
      |=> (pad_oe[i] == $past(dir_q[i]) && pad_out[i] == $past(port_dout[i]))); // R7
  end
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PINS-1:0]   reg_wdata,
  input  logic [PINS-1:0]   stat_bits,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   reg_rdata
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(ADDR_DIR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic            dir_hit;
  logic [PINS-1:0] rd_mux;

  assign dir_hit = reg_wr && (reg_addr == A_DIR);

  always_ff @(posedge clk) begin
    if (rst)          dir_q <= '0;
    else if (dir_hit) dir_q <= reg_wdata;
  end

  always_comb begin
    if (reg_addr == A_DIR)       rd_mux = dir_q;
    else if (reg_addr == A_STAT) rd_mux = stat_bits;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
    else             reg_rdata <= '0;
  end

  AST_DIR_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dir_q == '0); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_DIR) |=> dir_q == $past(reg_wdata)); // R1
  AST_OTHER_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr != A_DIR) |=> $stable(dir_q)); // R2
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> reg_rdata == '0); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr != A_DIR && reg_addr != A_STAT) |=> reg_rdata == '0); // R10
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int PINS        = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic              seg_mod_en,
  input  logic [PINS-1:0]   seg_pin_en,
  input  logic              tmr_mod_en,
  input  logic [PINS-1:0]   tmr_oc_sel,
  input  logic [PINS-1:0]   tmr_oc_val,
  input  logic [PINS-1:0]   port_dout,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out
);
  logic [PINS-1:0] pad_sync;
  logic [PINS-1:0] stat_bits;
  logic [PINS-1:0] dir_q;

  gpio_ovr_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  gpio_ovr_pinmux #(.PINS(PINS)) u_pinmux (
    .clk        (clk),
    .rst        (rst),
    .seg_mod_en (seg_mod_en),
    .seg_pin_en (seg_pin_en),
    .tmr_mod_en (tmr_mod_en),
    .tmr_oc_sel (tmr_oc_sel),
    .tmr_oc_val (tmr_oc_val),
    .port_dout  (port_dout),
    .dir_q      (dir_q),
    .pad_sync   (pad_sync),
    .stat_bits  (stat_bits),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out)
  );

  gpio_ovr_regs #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .stat_bits (stat_bits),
    .dir_q     (dir_q),
    .reg_rdata (reg_rdata)
  );

  for (genvar i = 0; i < PINS; i++) begin : g_chk
    AST_DISP_READS_ONE: assert property (@(posedge clk) disable iff (rst)
      (reg_rd && reg_addr == ADDR_W'(ADDR_STAT) && seg_mod_en && seg_pin_en[i])
      |=> reg_rdata[i]); // R3
  end
endmodule

// File: tb/gpio_ovr_port_tb_top.sv
module gpio_ovr_port_tb_top;
  localparam int PINS = 8;
  localparam int AW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [PINS-1:0] reg_wdata = '0, reg_rdata;
  logic            seg_mod_en = 1'b0, tmr_mod_en = 1'b0;
  logic [PINS-1:0] seg_pin_en = '0, tmr_oc_sel = '0, tmr_oc_val = '0;
  logic [PINS-1:0] port_dout = '0, pad_in = '0, pad_oe, pad_out;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  gpio_ovr_port #(.PINS(PINS), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seg_mod_en(seg_mod_en),
    .seg_pin_en(seg_pin_en), .tmr_mod_en(tmr_mod_en), .tmr_oc_sel(tmr_oc_sel),
    .tmr_oc_val(tmr_oc_val), .port_dout(port_dout), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [PINS-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [PINS-1:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [PINS-1:0] rd, dir_v, eoe, eout, estat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset oe", pad_oe, '0);
    check("R9 idle rdata", reg_rdata, '0);
    rd_reg(2'd0, rd);
    check("R1 dir reset", rd, '0);

    wr_reg(2'd0, 8'hA5);
    rd_reg(2'd0, rd);
    check("R1 dir readback", rd, 8'hA5);
    wr_reg(2'd1, 8'h3C);
    rd_reg(2'd0, rd);
    check("R2 status write ignored", rd, 8'hA5);
    wr_reg(2'd2, 8'hFF);
    wr_reg(2'd3, 8'h00);
    rd_reg(2'd0, rd);
    check("R10 unmapped write ignored", rd, 8'hA5);
    rd_reg(2'd2, rd);
    check("R10 unmapped read", rd, '0);
    rd_reg(2'd3, rd);
    check("R10 unmapped read", rd, '0);
    @(negedge clk);
    check("R9 no strobe zero", reg_rdata, '0);

    // R4 synchronizer latency
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    rd_reg(2'd1, rd);
    check("R4 one edge old level", rd, 8'h00);
    pad_in = 8'hC3;
    repeat (2) @(negedge clk);
    rd_reg(2'd1, rd);
    check("R4 two edges new level", rd, 8'hC3);
    rd_reg(2'd1, rd);
    check("R2 status after write", rd, 8'hC3);

    // R8 registered outputs
    wr_reg(2'd0, 8'hFF);
    port_dout = 8'h0F;
    @(negedge clk);
    port_dout = 8'hF0;
    #1 check("R8 before edge", pad_out, 8'h0F);
    @(negedge clk);
    check("R8 after edge", pad_out, 8'hF0);

    // Sweep: global enables x rotated per-pin patterns
    for (int g = 0; g < 4; g++) begin
      for (int k = 0; k < 32; k++) begin
        seg_mod_en = g[0];
        tmr_mod_en = g[1];
        for (int i = 0; i < PINS; i++) begin
          int p;
          p = (k + i * 5) % 32;
          seg_pin_en[i] = p[0];
          tmr_oc_sel[i] = p[1];
          tmr_oc_val[i] = p[2];
          dir_v[i]      = p[3];
          port_dout[i]  = p[4];
        end
        pad_in = 8'(k * 37 + g * 11);
        wr_reg(2'd0, dir_v);
        repeat (2) @(negedge clk);
        for (int i = 0; i < PINS; i++) begin
          logic disp, oc;
          disp = seg_mod_en & seg_pin_en[i];
          oc   = tmr_mod_en & tmr_oc_sel[i] & ~disp;
          eoe[i]   = disp ? 1'b0 : (oc ? 1'b1 : dir_v[i]);
          eout[i]  = disp ? 1'b0 : (oc ? tmr_oc_val[i] : port_dout[i]);
          estat[i] = disp ? 1'b1 : pad_in[i];
        end
        check("R5 R6 R7 pad_oe", pad_oe, eoe);
        check("R5 R6 R7 pad_out", pad_out, eout);
        rd_reg(2'd1, rd);
        check("R3 R4 status", rd, estat);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule